// File: doc/BRIEF.md
# Vectored Interrupt Controller with Stack Guard

This block arbitrates the interrupt requests of a small 8-bit controller core. It has three sources: a falling edge on an active-low external pin, a one-cycle overflow pulse from timer 0 and one from timer 1. Each source has a request flag that latches its event, and a per-source enable. A master enable gates all three. Software reads and writes all of these bits as one 8-bit control word over a simple register port.

When a pending source is enabled, the master enable is set and the core's return stack has room, the block raises a request to the core together with that source's fixed vector address. The core answers with an acknowledge in the cycle it commits to the push-and-jump. On that edge the block clears the master enable and the flag of the source it served, so that no other interrupt can nest until software allows it. Only the program counter is pushed by the core; the block saves nothing else. A separate wake output tells a halted core that an enabled source has a latched request, whatever the state of the master enable or the stack.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset the control word reads 0x00 and `irq_req` and `wake_req` are low.
- R2: A high-to-low transition seen on `ext_int_n` sets the external flag, which is control bit 4. A pin that stays low or rises sets nothing.
- R3: A one-cycle pulse on `tmr0_ovf` sets control bit 5 and a pulse on `tmr1_ovf` sets control bit 6, one clock later.
- R4: Control bit 0 is the master enable. Bits 1, 2 and 3 enable the external, timer 0 and timer 1 sources. A register write loads bits 0 to 6. Bit 7 always reads 0.
- R5: A latched flag whose own enable is clear never raises `irq_req`.
- R6: While `stack_full` is high, `irq_req` stays low and the flag stays latched. The request appears as soon as `stack_full` drops.
- R7: When several enabled flags are pending, the external source wins over timer 0, and timer 0 wins over timer 1. `irq_vector` is 0x04, 0x08 and 0x0C for the external, timer 0 and timer 1 sources, and is 0 while `irq_req` is low.
- R8: An `irq_ack` while `irq_req` is high clears the master enable and only the flag of the served source, on that clock edge.
- R9: Flags keep latching while the master enable is clear. Setting the master enable again by software lets the next pending source be served.
- R10: A hardware flag set in the same cycle as a software write of 0 to that flag leaves the flag set.
- R11: `wake_req` is high whenever a flag and its own enable are both set, regardless of the master enable and `stack_full`.
- R12: An `irq_ack` while `irq_req` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_int_n | input | 1 | External interrupt pin, active low, synchronous to clk |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| stack_full | input | 1 | Core's return stack has no free entry |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 8 | Write data for the control word |
| reg_rdata | output | 8 | Current control word |
| irq_ack | input | 1 | Core accepts the pending interrupt this cycle |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | PC_W | Vector address of the granted source |
| wake_req | output | 1 | Wake-up request for a halted core |

## Verification
A wrong flag or enable bit shows up on `reg_rdata` at the first negative edge after the clock edge that stored it, because the read path has no register. A wrong grant shows up at once on `irq_vector`, and a wrong gating term shows up at once on `irq_req` or `wake_req`. A missed clear on acknowledge shows up one cycle later as a repeated request or a stale flag bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // number of request sources, fixed by the control word layout
    localparam int NSRC       = 3;
    localparam int CTRL_W     = 8;
    localparam int MEN_BIT    = 0;
    localparam int EN_LSB     = 1;
    localparam int FLAG_LSB   = EN_LSB + NSRC;
    localparam int USED_BITS  = FLAG_LSB + NSRC;
    localparam int VEC_STRIDE = 4;

    typedef enum logic [1:0] {
        SRC_EXT = 2'd0,
        SRC_TM0 = 2'd1,
        SRC_TM1 = 2'd2
    } src_e;

    typedef struct packed {
        logic [NSRC-1:0] flag;
        logic [NSRC-1:0] en;
        logic            men;
    } ctrl_t;

    // vector address for source index idx: 4, 8, 12 ...
    function automatic int vec_addr(input int idx);
        return (idx + 1) * VEC_STRIDE;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[MEN_BIT]              = c.men;
        w[EN_LSB +: NSRC]       = c.en;
        w[FLAG_LSB +: NSRC]     = c.flag;
        return w;
    endfunction

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= pin_n;
    end

    assign fall = last_q & ~pin_n;

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic [NSRC-1:0]   hw_set,
    input  logic              take,
    input  logic [NSRC-1:0]   take_sel,
    output ctrl_t             ctrl,
    output logic [CTRL_W-1:0] rdata
);
    ctrl_t ctrl_q, ctrl_d;
    logic [NSRC-1:0] flag_base;

    always_comb begin
        ctrl_d    = ctrl_q;
        flag_base = ctrl_q.flag;
        if (wr) begin
            ctrl_d.men = wdata[MEN_BIT];
            ctrl_d.en  = wdata[EN_LSB +: NSRC];
            flag_base  = wdata[FLAG_LSB +: NSRC];
        end
        if (take) begin
            ctrl_d.men = 1'b0;
            flag_base  = flag_base & ~take_sel;
        end
        ctrl_d.flag = flag_base | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign ctrl  = ctrl_q;
    assign rdata = ctrl_to_word(ctrl_q);

    // R8
    men_cleared_on_take_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !ctrl_q.men);

    // R12
    idle_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!take && !wr && hw_set == '0) |=> $stable(ctrl_q));

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_flag_chk
            // R10
            hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
                hw_set[i] |=> ctrl_q.flag[i]);

            // R8
            served_flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (take && take_sel[i] && !hw_set[i]) |=> !ctrl_q.flag[i]);
        end
    endgenerate

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
#(
    parameter int PC_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic              stack_full,
    output logic [NSRC-1:0]   grant,
    output logic              req,
    output logic [PC_W-1:0]   vector,
    output logic              wake
);
    logic [NSRC-1:0] pend;
    logic            any_pend;

    assign pend = ctrl.en & ctrl.flag;

    // lowest index wins
    always_comb begin
        grant    = '0;
        any_pend = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (!any_pend && pend[i]) begin
                grant[i] = 1'b1;
                any_pend = 1'b1;
            end
        end
    end

    assign req  = ctrl.men & any_pend & ~stack_full;
    assign wake = |pend;

    always_comb begin
        vector = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req && grant[i]) vector = PC_W'(vec_addr(i));
        end
    end

    // R7
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> $onehot(grant));

    // R6
    no_req_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        stack_full |-> (vector == '0));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int PC_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_int_n,
    input  logic              tmr0_ovf,
    input  logic              tmr1_ovf,
    input  logic              stack_full,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [PC_W-1:0]   irq_vector,
    output logic              wake_req
);
    logic            ext_fall;
    logic [NSRC-1:0] hw_set;
    logic [NSRC-1:0] grant;
    logic            take;
    ctrl_t           ctrl;

    irqc_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .pin_n (ext_int_n),
        .fall  (ext_fall)
    );

    always_comb begin
        hw_set          = '0;
        hw_set[SRC_EXT] = ext_fall;
        hw_set[SRC_TM0] = tmr0_ovf;
        hw_set[SRC_TM1] = tmr1_ovf;
    end

    assign take = irq_req & irq_ack;

    irqc_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .hw_set   (hw_set),
        .take     (take),
        .take_sel (grant),
        .ctrl     (ctrl),
        .rdata    (reg_rdata)
    );

    irqc_arb #(.PC_W(PC_W)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .stack_full (stack_full),
        .grant      (grant),
        .req        (irq_req),
        .vector     (irq_vector),
        .wake       (wake_req)
    );

endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

    localparam int PC_W = 11;
    localparam int WATCHDOG = 20000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ext_int_n = 1'b1;
    logic            tmr0_ovf = 1'b0;
    logic            tmr1_ovf = 1'b0;
    logic            stack_full = 1'b0;
    logic            reg_wr = 1'b0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic            irq_ack = 1'b0;
    logic            irq_req;
    logic [PC_W-1:0] irq_vector;
    logic            wake_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic [7:0]      rd;
        logic            req;
        logic [PC_W-1:0] vec;
        logic            wake;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    always #2 clk = ~clk;

    irq_vector_ctrl #(.PC_W(PC_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .ext_int_n  (ext_int_n),
        .tmr0_ovf   (tmr0_ovf),
        .tmr1_ovf   (tmr1_ovf),
        .stack_full (stack_full),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_ack    (irq_ack),
        .irq_req    (irq_req),
        .irq_vector (irq_vector),
        .wake_req   (wake_req)
    );

    // monitor: compares outputs against queued expectations
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            checks++;
            if (reg_rdata !== cur.rd || irq_req !== cur.req ||
                irq_vector !== cur.vec || wake_req !== cur.wake) begin
                errors++;
                $display("FAIL %s: rdata=%h req=%b vec=%h wake=%b expected rdata=%h req=%b vec=%h wake=%b",
                         cur.tag, reg_rdata, irq_req, irq_vector, wake_req,
                         cur.rd, cur.req, cur.vec, cur.wake);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic [7:0] rd, input logic req,
                              input logic [PC_W-1:0] vec, input logic wake,
                              input string tag);
        exp_t e;
        e.rd = rd; e.req = req; e.vec = vec; e.wake = wake; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr_reg(input logic [7:0] v);
        step();
        reg_wr = 1'b1;
        reg_wdata = v;
        step();
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        expect_out(8'h00, 1'b0, 11'h000, 1'b0, "R1 reset");

        // R4: bit 7 dropped, bits 0..6 loaded; R7 external first
        wr_reg(8'hFF);
        expect_out(8'h7F, 1'b1, 11'h004, 1'b1, "R4 write");

        // R6: stack full holds the request off
        step(); stack_full = 1'b1;
        expect_out(8'h7F, 1'b0, 11'h000, 1'b1, "R6 held");
        step(); stack_full = 1'b0;
        expect_out(8'h7F, 1'b1, 11'h004, 1'b1, "R6 release");

        // R8: acknowledge external
        step(); irq_ack = 1'b1;
        expect_out(8'h7F, 1'b1, 11'h004, 1'b1, "R7 ext vector");
        step(); irq_ack = 1'b0;
        expect_out(8'h6E, 1'b0, 11'h000, 1'b1, "R8 ext served");

        // R12: stray acknowledge
        step(); irq_ack = 1'b1;
        expect_out(8'h6E, 1'b0, 11'h000, 1'b1, "R12 before");
        step(); irq_ack = 1'b0;
        expect_out(8'h6E, 1'b0, 11'h000, 1'b1, "R12 after");

        // R9: re-enable master, timer 0 next
        wr_reg(8'h6F);
        expect_out(8'h6F, 1'b1, 11'h008, 1'b1, "R9 nesting tm0");
        step(); irq_ack = 1'b1;
        step(); irq_ack = 1'b0;
        expect_out(8'h4E, 1'b0, 11'h000, 1'b1, "R8 tm0 served");
        wr_reg(8'h4F);
        expect_out(8'h4F, 1'b1, 11'h00C, 1'b1, "R7 tm1 vector");
        step(); irq_ack = 1'b1;
        step(); irq_ack = 1'b0;
        expect_out(8'h0E, 1'b0, 11'h000, 1'b0, "R8 tm1 served");

        // R2: falling edge, steady low, rising
        step(); ext_int_n = 1'b0;
        step();
        expect_out(8'h1E, 1'b0, 11'h000, 1'b1, "R2 fall");
        wr_reg(8'h0E);
        expect_out(8'h0E, 1'b0, 11'h000, 1'b0, "R2 steady low");
        step(); ext_int_n = 1'b1;
        step(); step();
        expect_out(8'h0E, 1'b0, 11'h000, 1'b0, "R2 rising");

        // R3: timer pulses
        step(); tmr0_ovf = 1'b1;
        step(); tmr0_ovf = 1'b0;
        expect_out(8'h2E, 1'b0, 11'h000, 1'b1, "R3 tm0");
        step(); tmr1_ovf = 1'b1;
        step(); tmr1_ovf = 1'b0;
        expect_out(8'h6E, 1'b0, 11'h000, 1'b1, "R3 tm1");

        // R11: wake depends on source enable only
        wr_reg(8'h00);
        expect_out(8'h00, 1'b0, 11'h000, 1'b0, "R4 clear");
        step(); tmr1_ovf = 1'b1;
        step(); tmr1_ovf = 1'b0;
        expect_out(8'h40, 1'b0, 11'h000, 1'b0, "R11 disabled");
        wr_reg(8'h48);
        expect_out(8'h48, 1'b0, 11'h000, 1'b1, "R11 men clear");
        step(); stack_full = 1'b1;
        wr_reg(8'h49);
        expect_out(8'h49, 1'b0, 11'h000, 1'b1, "R6 R11 stack full");
        step(); stack_full = 1'b0;
        expect_out(8'h49, 1'b1, 11'h00C, 1'b1, "R6 drop");

        // R10: hardware set wins over write of 0
        step(); reg_wr = 1'b1; reg_wdata = 8'h00; tmr0_ovf = 1'b1;
        step(); reg_wr = 1'b0; tmr0_ovf = 1'b0;
        expect_out(8'h20, 1'b0, 11'h000, 1'b0, "R10 set wins");

        // R5: own enable required
        wr_reg(8'h21);
        expect_out(8'h21, 1'b0, 11'h000, 1'b0, "R5 enable off");
        wr_reg(8'h25);
        expect_out(8'h25, 1'b1, 11'h008, 1'b1, "R5 enable on");

        // R1: reset mid-run
        step(); rst = 1'b1;
        step(); step(); rst = 1'b0;
        expect_out(8'h00, 1'b0, 11'h000, 1'b0, "R1 mid reset");

        step(); step();
        finish_run();
    end

endmodule